// File: doc/BRIEF.md
# Bus-Clocked I2C Register Write/Read Target

This block is a 7-bit-address I2C target that gives a bus master write and read access to a small bank of 8-bit control registers. It has no system clock. Its sequential logic runs on the bus lines themselves. Falling edges of SCL advance the byte engine, and rising edges of SCL sample SDA. Edges of SDA while SCL is high mark the bus conditions: a falling edge is a START and a rising edge is a STOP. The block answers only the fixed device address 7'h60.

A write transaction has three parts. First comes the address byte with direction bit 0. The next byte loads a register pointer. Every byte after that is stored at the pointer, and the pointer then increments. A read transaction uses the address byte with direction bit 1. The target then shifts out the pointed register MSB first and increments the pointer after each byte. It continues until the master answers a byte with NACK. Repeated START behaves exactly like START. The register contents are presented in parallel on a flat output bus that feeds the controlled logic. SDA is open-drain: the block outputs only a pull-low enable.

Reset is active-high. It acts asynchronously, because SCL may be idle while reset is asserted.

Top module: `i2c_reg_target`

## Requirements
- R1: While and after reset, every register reads 0x00, the SDA pull-low enable is off and the bus-busy flag is low.
- R2: SDA falling while SCL is high raises the bus-busy flag. SDA rising while SCL is high clears it and releases SDA. A new transaction after a STOP again treats its first byte after the address as a pointer.
- R3: An address byte whose upper 7 bits equal 7'h60 is acknowledged: SDA is held low during the ninth SCL high phase.
- R4: For any other address, SDA stays released through the acknowledge slot and all following bytes, and no register changes until the next START.
- R5: In a write (bit 0 of the address byte = 0), the second byte sets the pointer and the third byte is stored in the register at that pointer. Register i appears at regs_o[8*i+7:8*i]. Both bytes are acknowledged.
- R6: Each further written byte goes to the next register (pointer + 1) and is acknowledged.
- R7: A write whose pointer is 16 or higher is acknowledged but changes no register. This includes a pointer that has incremented past 15.
- R8: In a read (bit 0 of the address byte = 1), the target sends the register at the pointer MSB first. It releases SDA in the ninth clock. After a master ACK (SDA low in the ninth clock), it sends the next register.
- R9: After a master NACK (SDA high in the ninth clock), the target keeps SDA released until the next START.
- R10: A repeated START, even in the middle of a byte, discards the partial byte and restarts address reception.
- R11: A read from a pointer of 16 or higher returns 0x00.
- R12: The target changes its SDA drive only while SCL is low, so SDA is stable during every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Active-high reset, asynchronous |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull-low enable for the open-drain SDA pad |
| busy_o | output | 1 | High between a START and the following STOP |
| regs_o | output | NREG*8 | All registers in parallel, register i at bits 8*i+7:8*i |

## Verification
The hardest situation to reach is a repeated START that arrives in the middle of a byte. The byte counter and the partial shift contents must then be thrown away without any drive or write leaking out. The stimulus gets there by clocking three bits of a pointer byte and then raising SDA while SCL is low, followed by a START. It then checks that a fresh address byte is acknowledged and that the write lands at the pointer given afterwards. A second hard case is a read that runs past the last implemented register into the zero-filled range, ends with a NACK, and is followed by further clocks. The bench reads those clocks back to show that SDA stays released.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IGNORE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_RD
  } tgt_state_t;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
endpackage

// File: rtl/i2c_bus_cond.sv
`timescale 1ns/1ps
// Detects START and STOP from SDA edges qualified by SCL high.
module i2c_bus_cond (
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_tgl_o,
  output logic busy_o
);
  logic start_par;
  logic stop_tgl;

  // START: SDA falls while SCL high
  always_ff @(negedge sda_i or posedge rst) begin
    if (rst) begin
      start_tgl_o <= 1'b0;
      start_par   <= 1'b0;
    end else if (scl_i) begin
      start_tgl_o <= ~start_tgl_o;
      start_par   <= ~stop_tgl;
    end
  end

  // STOP: SDA rises while SCL high
  always_ff @(posedge sda_i or posedge rst) begin
    if (rst) stop_tgl <= 1'b0;
    else if (scl_i) stop_tgl <= ~stop_tgl;
  end

  // busy after a START until the STOP that follows it
  assign busy_o = start_par ^ stop_tgl;
endmodule

// File: rtl/i2c_reg_bank.sv
`timescale 1ns/1ps
// Register bank written on the falling bus clock, read combinationally.
module i2c_reg_bank #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  parameter int AW   = 8
) (
  input  logic               rst,
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] q_o
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] mem [NREG];
  logic          in_range;

  assign in_range = (int'(addr) < NREG);

  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we && in_range) begin
      mem[addr[IW-1:0]] <= wdata;
    end
  end

  assign rdata = in_range ? mem[addr[IW-1:0]] : '0;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign q_o[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/i2c_reg_target.sv
`timescale 1ns/1ps
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h60,
  parameter int         NREG     = 16
) (
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic                   busy_o,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  logic              start_tgl, start_seen, start_pend;
  logic              sda_smp;
  tgt_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [6:0]        sh;
  logic [7:0]        byte_now;
  logic              rw;
  logic [7:0]        ptr;
  logic [6:0]        tx;
  logic              drv;
  logic              wr_en;
  logic [7:0]        rd_data;

  i2c_bus_cond u_cond (
    .rst         (rst),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .start_tgl_o (start_tgl),
    .busy_o      (busy_o)
  );

  assign start_pend = start_tgl ^ start_seen;
  assign byte_now   = {sh, sda_smp};

  // sample data while SCL is high
  always_ff @(posedge scl_i or posedge rst) begin
    if (rst) sda_smp <= 1'b1;
    else     sda_smp <= sda_i;
  end

  assign wr_en = busy_o && !start_pend && (st == ST_WR) && (cnt == LAST_BIT);

  i2c_reg_bank #(.NREG(NREG), .DW(BYTE_W), .AW(8)) u_bank (
    .rst   (rst),
    .clk   (scl_i),
    .we    (wr_en),
    .addr  (ptr),
    .wdata (byte_now),
    .rdata (rd_data),
    .q_o   (regs_o)
  );

  // byte engine: advances on SCL falling edge, drive changes only here
  always_ff @(negedge scl_i or posedge rst) begin
    if (rst) begin
      start_seen <= 1'b0;
      st         <= ST_IGNORE;
      cnt        <= '0;
      sh         <= '0;
      rw         <= 1'b0;
      ptr        <= '0;
      tx         <= '0;
      drv        <= 1'b0;
    end else if (start_pend) begin
      start_seen <= start_tgl;
      st         <= ST_ADDR;
      cnt        <= '0;
      drv        <= 1'b0;
    end else if (!busy_o) begin
      st  <= ST_IGNORE;
      cnt <= '0;
      drv <= 1'b0;
    end else if (cnt != ACK_SLOT) begin
      sh  <= byte_now[6:0];
      cnt <= cnt + 1'b1;
      drv <= 1'b0;
      if (cnt == LAST_BIT) begin
        unique case (st)
          ST_ADDR: begin
            if (byte_now[7:1] == DEV_ADDR) begin
              drv <= 1'b1;
              rw  <= byte_now[0];
            end else begin
              st <= ST_IGNORE;
            end
          end
          ST_PTR: begin
            ptr <= byte_now;
            drv <= 1'b1;
          end
          ST_WR: begin
            ptr <= ptr + 1'b1;
            drv <= 1'b1;
          end
          ST_RD:     ptr <= ptr + 1'b1;
          ST_IGNORE: ;
          default:   ;
        endcase
      end else if (st == ST_RD) begin
        drv <= ~tx[6];
        tx  <= {tx[5:0], 1'b0};
      end
    end else begin
      cnt <= '0;
      drv <= 1'b0;
      unique case (st)
        ST_ADDR: begin
          if (rw) begin
            st  <= ST_RD;
            tx  <= rd_data[6:0];
            drv <= ~rd_data[7];
          end else begin
            st <= ST_PTR;
          end
        end
        ST_PTR: st <= ST_WR;
        ST_RD: begin
          if (!sda_smp) begin
            tx  <= rd_data[6:0];
            drv <= ~rd_data[7];
          end else begin
            st <= ST_IGNORE;
          end
        end
        ST_WR:     ;
        ST_IGNORE: ;
        default:   ;
      endcase
    end
  end

  assign sda_oe_o = drv & busy_o;
endmodule

// File: rtl/i2c_reg_target_chk.sv
`timescale 1ns/1ps
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int NREG = 16
) (
  input logic                   rst,
  input logic                   scl_i,
  input logic                   sda_oe_o,
  input logic                   busy_o,
  input logic [NREG*BYTE_W-1:0] regs_o,
  input tgt_state_t             st,
  input logic [CNT_W-1:0]       cnt,
  input logic                   start_pend,
  input logic [7:0]             byte_now,
  input logic [7:0]             ptr
);
  // R1: quiet bus outputs during reset
  always_comb begin
    if (rst) begin
      a_r1_reset_quiet: assert (!sda_oe_o && !busy_o && regs_o == '0)
        else $error("R1 outputs active in reset");
    end
  end

  // R3: matching address is acknowledged in the next slot
  a_r3_ack_on_match: assert property (@(negedge scl_i) disable iff (rst)
    (st == ST_ADDR && cnt == 4'd7 && busy_o && !start_pend && byte_now[7:1] == 7'h60)
    |=> sda_oe_o);

  // R4: an ignored transaction never drives SDA
  a_r4_ignore_silent: assert property (@(posedge scl_i) disable iff (rst)
    (st == ST_IGNORE) |-> !sda_oe_o);

  // R5: registers only change while writing
  a_r5_write_only_in_wr: assert property (@(negedge scl_i) disable iff (rst)
    (st != ST_WR) |=> $stable(regs_o));

  // R7: out-of-range pointer leaves the bank untouched
  a_r7_discard_high_ptr: assert property (@(negedge scl_i) disable iff (rst)
    (st == ST_WR && int'(ptr) >= NREG) |=> $stable(regs_o));

  // R9: master NACK ends the read
  a_r9_nack_ends_read: assert property (@(negedge scl_i) disable iff (rst)
    (st == ST_RD && cnt == 4'd8 && byte_now[0] && busy_o && !start_pend)
    |=> (st == ST_IGNORE));

  // R12: drive changes only while SCL is low
  always @(sda_oe_o) begin
    if (!rst) begin
      a_r12_drive_scl_low: assert (!scl_i) else $error("R12 SDA drive changed with SCL high");
    end
  end
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/tb_i2c_reg_target.sv
`timescale 1ns/1ps
module tb_i2c_reg_target;
  localparam int CLK_PERIOD = 2500;
  localparam int Q          = CLK_PERIOD / 4;
  localparam int NREG       = 16;
  localparam logic [7:0] AW = 8'hC0;
  localparam logic [7:0] AR = 8'hC1;

  logic rst, scl, m_low;
  logic sda_line;
  logic sda_oe, busy;
  logic [NREG*8-1:0] regs;
  logic [7:0] exp_r [NREG];
  int n_chk = 0, n_fail = 0;

  assign sda_line = !(m_low || sda_oe);

  i2c_reg_target #(.DEV_ADDR(7'h60), .NREG(NREG)) dut (
    .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_o(busy), .regs_o(regs)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic bit_out(input logic b);
    #Q m_low = !b;
    #Q scl = 1'b1;
    #(2*Q) scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    logic v1;
    #Q m_low = 1'b0;
    #Q scl = 1'b1;
    #(Q/2) v1 = sda_line;
    #Q b = sda_line;
    chk(v1 == b, "R12", {31'd0, b}, {31'd0, v1});
    #(Q/2) scl = 1'b0;
  endtask

  task automatic start_c();
    #Q m_low = 1'b0;
    #Q scl = 1'b1;
    #Q m_low = 1'b1;
    #Q scl = 1'b0;
  endtask

  task automatic stop_c();
    #Q m_low = 1'b1;
    #Q scl = 1'b1;
    #Q m_low = 1'b0;
    #Q;
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = !a;
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(!mack);
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs[i*8 +: 8] == exp_r[i], req, {24'd0, regs[i*8 +: 8]}, {24'd0, exp_r[i]});
  endtask

  initial begin
    #(longint'(CLK_PERIOD) * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    scl = 1'b1; m_low = 1'b0; rst = 1'b1;
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
    #(2*CLK_PERIOD);
    chk(sda_oe == 1'b0 && busy == 1'b0, "R1", {30'd0, sda_oe, busy}, 32'd0);
    chk_regs("R1");
    rst = 1'b0;
    #CLK_PERIOD;

    // R2 busy flag
    start_c();
    chk(busy == 1'b1, "R2", {31'd0, busy}, 32'd1);
    stop_c();
    chk(busy == 1'b0 && sda_oe == 1'b0, "R2", {30'd0, busy, sda_oe}, 32'd0);

    // R3/R5 single write
    start_c();
    send(AW, ack);   chk(ack, "R3", {31'd0, ack}, 32'd1);
    send(8'h03, ack); chk(ack, "R5", {31'd0, ack}, 32'd1);
    send(8'hA5, ack); chk(ack, "R5", {31'd0, ack}, 32'd1);
    stop_c();
    exp_r[3] = 8'hA5;
    chk_regs("R5");

    // R6 burst across the whole bank
    start_c();
    send(AW, ack);   chk(ack, "R3", {31'd0, ack}, 32'd1);
    send(8'h00, ack); chk(ack, "R6", {31'd0, ack}, 32'd1);
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 11);
      send(v, ack); chk(ack, "R6", {31'd0, ack}, 32'd1);
      exp_r[i] = v;
    end
    stop_c();
    chk_regs("R6");

    // R7 out of range pointer and increment past the end
    start_c();
    send(AW, ack);
    send(8'h1E, ack); chk(ack, "R7", {31'd0, ack}, 32'd1);
    send(8'h55, ack); chk(ack, "R7", {31'd0, ack}, 32'd1);
    send(8'h66, ack); chk(ack, "R7", {31'd0, ack}, 32'd1);
    stop_c();
    chk_regs("R7");
    start_c();
    send(AW, ack);
    send(8'h0F, ack);
    send(8'h12, ack);
    send(8'h34, ack); chk(ack, "R7", {31'd0, ack}, 32'd1);
    stop_c();
    exp_r[15] = 8'h12;
    chk_regs("R7");

    // R4 sweep over every other address
    for (int a = 0; a < 128; a++) begin
      logic any;
      if (a == 'h60) continue;
      any = 1'b0;
      start_c();
      send({7'(a), 1'(a & 1)}, ack); any |= ack;
      send(8'h02, ack); any |= ack;
      send(8'h00, ack); any |= ack;
      stop_c();
      chk(!any, "R4", {31'd0, any}, 32'd0);
    end
    chk_regs("R4");

    // R8/R11/R9 read across the end of the bank with repeated START
    start_c();
    send(AW, ack);
    send(8'h0E, ack);
    start_c();
    send(AR, ack); chk(ack, "R8", {31'd0, ack}, 32'd1);
    recv(1'b1, rb); chk(rb == exp_r[14], "R8", {24'd0, rb}, {24'd0, exp_r[14]});
    recv(1'b1, rb); chk(rb == exp_r[15], "R8", {24'd0, rb}, {24'd0, exp_r[15]});
    recv(1'b0, rb); chk(rb == 8'h00, "R11", {24'd0, rb}, 32'd0);
    for (int i = 7; i >= 0; i--) bit_in(rb[i]);
    chk(rb == 8'hFF, "R9", {24'd0, rb}, 32'hFF);
    bit_in(rb[0]);
    chk(rb[0] == 1'b1, "R9", {31'd0, rb[0]}, 32'd1);
    stop_c();

    // R8 burst read from pointer 4
    start_c();
    send(AW, ack);
    send(8'h04, ack);
    start_c();
    send(AR, ack); chk(ack, "R8", {31'd0, ack}, 32'd1);
    for (int i = 4; i < 8; i++) begin
      recv(i != 7, rb);
      chk(rb == exp_r[i], "R8", {24'd0, rb}, {24'd0, exp_r[i]});
    end
    stop_c();

    // R10 repeated START in the middle of a pointer byte
    start_c();
    send(AW, ack);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    start_c();
    send(AW, ack);   chk(ack, "R10", {31'd0, ack}, 32'd1);
    send(8'h09, ack); chk(ack, "R10", {31'd0, ack}, 32'd1);
    send(8'h3C, ack);
    stop_c();
    exp_r[9] = 8'h3C;
    chk_regs("R10");

    // R2 STOP after pointer, new transaction starts with pointer again
    start_c();
    send(AW, ack);
    send(8'h02, ack);
    stop_c();
    chk(busy == 1'b0 && sda_oe == 1'b0, "R2", {30'd0, busy, sda_oe}, 32'd0);
    start_c();
    send(AW, ack);
    send(8'h07, ack);
    send(8'h99, ack);
    stop_c();
    exp_r[7] = 8'h99;
    chk_regs("R2");

    #CLK_PERIOD;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule